// File: doc/BRIEF.md
# Block-Granular Security Access Filter

This block sits between one bus master and a downstream memory and decides, for each access, whether it may reach the memory. The memory space is cut into equal blocks of `BLK_BYTES` bytes. A table of 32-bit words holds one bit per block, and that bit names the single security world that may use the block. Every access carries a non-secure flag. If the flag matches the block's bit, the access goes downstream unchanged. If not, it is stopped. A stopped read returns zero, a stopped write is dropped, and the access is reported on a side channel.

Software programs the filter through a small word-indexed register port. An index register selects one table word, and a data register reads or replaces that word. The index can step forward by itself after each full-word table access, which lets software load the whole table with a run of writes. A sticky status bit records stopped accesses and drives an interrupt through an enable bit. A control bit chooses whether a stopped access also returns an error response.

Top module: `blk_sec_filter`

## Requirements
- R1: An access at byte address A falls in block A / BLK_BYTES. That block is controlled by bit (block mod 32) of table word (block / 32).
- R2: When the block's bit is 1, only accesses with `up_ns`=1 are forwarded. When the bit is 0, only accesses with `up_ns`=0 are forwarded. A forwarded access raises `dn_valid` in the same cycle, with address, size, write flag and write data passed through unchanged, and `up_rdata` equal to `dn_rdata`.
- R3: A stopped access keeps `dn_valid` low, so a stopped write never reaches the memory. A stopped read returns `up_rdata`=0. In the same cycle `blk_evt` is 1 and `blk_write`, `blk_ns`, `blk_addr` and `blk_size` show the access's write flag, security flag, address and size.
- R4: A write to the index register (offset 1) stores the written value modulo `N_WORDS`. Reading offset 1 returns the index.
- R5: A write to the table register (offset 2) replaces the whole word at the current index, whatever the access size. A read of offset 2 returns that word. A new word governs accesses from the next clock cycle on.
- R6: The index advances by one after a table-register read or write only when control bit 0 (offset 0) is 1 and `cfg_size` is 2 (full word; 0 is a byte, 1 is a halfword). After word `N_WORDS`-1 the index wraps to 0.
- R7: A stopped access sets the status bit (offset 3, bit 0) on the next clock edge. The bit stays set until 1 is written to bit 0 of the clear register (offset 5). Writing 0 there has no effect. If a clear and a stopped access happen in the same cycle, the bit stays set.
- R8: `irq` is 1 exactly when the status bit is 1 and the enable bit (offset 4, bit 0) is 1.
- R9: When control bit 1 is 1, a stopped access drives `up_err`=1. When control bit 1 is 0, it drives `up_err`=0. A forwarded access always drives `up_err`=0.
- R10: After reset, every table word, the index, the control register, the status bit and the enable bit read 0, so every block is secure-only. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cfg_sel | input | 1 | Register access in this cycle |
| cfg_wr | input | 1 | 1 = register write, 0 = register read |
| cfg_addr | input | 3 | Register word offset |
| cfg_size | input | 2 | Register access size: 0 byte, 1 halfword, 2 word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid in the access cycle |
| up_valid | input | 1 | Upstream access present |
| up_write | input | 1 | Upstream access is a write |
| up_ns | input | 1 | Upstream access is non-secure |
| up_addr | input | AW | Upstream byte address |
| up_size | input | 2 | Upstream access size |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Read data returned upstream |
| up_err | output | 1 | Error response upstream |
| dn_valid | output | 1 | Forwarded access to memory |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | AW | Forwarded address |
| dn_size | output | 2 | Forwarded size |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 32 | Read data from memory |
| blk_evt | output | 1 | A stopped access in this cycle |
| blk_write | output | 1 | Stopped access was a write |
| blk_ns | output | 1 | Stopped access was non-secure |
| blk_addr | output | AW | Address of the stopped access |
| blk_size | output | 2 | Size of the stopped access |
| irq | output | 1 | Interrupt request |

## Verification
Accesses are sent in all four combinations of security flag and block bit: secure to secure, non-secure to non-secure, and each world to the other's block. A matching pair separates a correct match from an inverted compare. Addresses at the first and last bit of a word, and just past a changed block, show whether the word and bit selection is right and whether a change stays limited to the intended block. Table-register accesses of byte and word size, with auto-increment on and off and starting from the last index, separate the increment condition from the wrap. A clear that arrives in the same cycle as a stopped access shows which of the two takes priority.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  typedef enum logic [2:0] {
    OFS_CTRL  = 3'd0,
    OFS_INDEX = 3'd1,
    OFS_TABLE = 3'd2,
    OFS_STAT  = 3'd3,
    OFS_EN    = 3'd4,
    OFS_CLR   = 3'd5
  } bsf_ofs_e;

  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam int unsigned BITS_PER_WORD = 32;
endpackage

// File: rtl/bsf_rst_sync.sv
module bsf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/bsf_lut.sv
module bsf_lut #(
  parameter int N_WORDS = 4,
  parameter int AW      = 12,
  parameter int BW      = 5,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int WW     = AW - BW - 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rword,
  input  logic [AW-1:0] look_addr,
  output logic          look_ns
);
  logic [31:0] mem_q [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic word_en;
    assign word_en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (word_en) mem_q[g] <= wdata;
    end
  end

  logic [WW-1:0] look_word;
  logic [4:0]    look_bit;

  always_comb begin
    look_word = look_addr[AW-1 -: WW];
    look_bit  = look_addr[BW +: 5];
    rword     = mem_q[ridx];
    look_ns   = 1'b0;
    if (32'(look_word) < 32'(N_WORDS)) look_ns = mem_q[look_word][look_bit];
  end
endmodule

// File: rtl/bsf_regs.sv
module bsf_regs
  import bsf_pkg::*;
#(
  parameter int N_WORDS = 4,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [1:0]    cfg_size,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [31:0]   lut_rword,
  input  logic          blk_hit,
  output logic [IW-1:0] idx_q,
  output logic          lut_we,
  output logic          irq_stat_q,
  output logic          irq_en_q,
  output logic          err_mode
);
  logic [1:0]    ctrl_q, ctrl_d;
  logic [IW-1:0] idx_d;
  logic          stat_d, en_d;
  logic          ctrl_ce, idx_ce, stat_ce, en_ce;
  logic          wr, tbl_acc, step;

  always_comb begin
    wr      = cfg_sel && cfg_wr;
    tbl_acc = cfg_sel && (cfg_addr == OFS_TABLE);
    step    = tbl_acc && ctrl_q[0] && (cfg_size == SZ_WORD);
    lut_we  = wr && (cfg_addr == OFS_TABLE);

    ctrl_ce = wr && (cfg_addr == OFS_CTRL);
    ctrl_d  = cfg_wdata[1:0];

    idx_ce = step || (wr && (cfg_addr == OFS_INDEX));
    if (step) idx_d = (32'(idx_q) == N_WORDS - 1) ? '0 : idx_q + 1'b1;
    else      idx_d = IW'(cfg_wdata % 32'(N_WORDS));

    en_ce = wr && (cfg_addr == OFS_EN);
    en_d  = cfg_wdata[0];

    stat_ce = blk_hit || (wr && (cfg_addr == OFS_CLR) && cfg_wdata[0]);
    stat_d  = blk_hit;

    cfg_rdata = '0;
    if (cfg_sel && !cfg_wr) begin
      case (cfg_addr)
        OFS_CTRL:  cfg_rdata = {30'd0, ctrl_q};
        OFS_INDEX: cfg_rdata = 32'(idx_q);
        OFS_TABLE: cfg_rdata = lut_rword;
        OFS_STAT:  cfg_rdata = {31'd0, irq_stat_q};
        OFS_EN:    cfg_rdata = {31'd0, irq_en_q};
        default:   cfg_rdata = '0;
      endcase
    end
  end

  assign err_mode = ctrl_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      idx_q      <= '0;
      irq_stat_q <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      if (ctrl_ce) ctrl_q     <= ctrl_d;
      if (idx_ce)  idx_q      <= idx_d;
      if (stat_ce) irq_stat_q <= stat_d;
      if (en_ce)   irq_en_q   <= en_d;
    end
  end
endmodule

// File: rtl/bsf_gate.sv
module bsf_gate (
  input  logic        up_valid,
  input  logic        up_ns,
  input  logic        blk_ns_bit,
  input  logic        err_mode,
  input  logic [31:0] dn_rdata,
  output logic        dn_valid,
  output logic [31:0] up_rdata,
  output logic        up_err,
  output logic        blk_evt
);
  logic pass;

  always_comb begin
    pass     = (blk_ns_bit == up_ns);
    dn_valid = up_valid && pass;
    blk_evt  = up_valid && !pass;
    up_rdata = dn_valid ? dn_rdata : '0;
    up_err   = blk_evt && err_mode;
  end
endmodule

// File: rtl/blk_sec_filter.sv
module blk_sec_filter #(
  parameter int N_WORDS   = 4,
  parameter int BLK_BYTES = 32,
  localparam int AW       = $clog2(N_WORDS * 32 * BLK_BYTES),
  localparam int BW       = $clog2(BLK_BYTES),
  localparam int IW       = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [1:0]    cfg_size,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          up_valid,
  input  logic          up_write,
  input  logic          up_ns,
  input  logic [AW-1:0] up_addr,
  input  logic [1:0]    up_size,
  input  logic [31:0]   up_wdata,
  output logic [31:0]   up_rdata,
  output logic          up_err,
  output logic          dn_valid,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [1:0]    dn_size,
  output logic [31:0]   dn_wdata,
  input  logic [31:0]   dn_rdata,
  output logic          blk_evt,
  output logic          blk_write,
  output logic          blk_ns,
  output logic [AW-1:0] blk_addr,
  output logic [1:0]    blk_size,
  output logic          irq
);
  logic          rst_sync_n;
  logic [IW-1:0] idx_q;
  logic          lut_we, irq_stat_q, irq_en_q, err_mode, look_ns;
  logic [31:0]   lut_rword;

  bsf_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bsf_regs #(.N_WORDS(N_WORDS)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lut_rword(lut_rword), .blk_hit(blk_evt),
    .idx_q(idx_q), .lut_we(lut_we), .irq_stat_q(irq_stat_q),
    .irq_en_q(irq_en_q), .err_mode(err_mode)
  );

  bsf_lut #(.N_WORDS(N_WORDS), .AW(AW), .BW(BW)) i_lut (
    .clk(clk), .rst_n(rst_sync_n), .we(lut_we), .widx(idx_q),
    .wdata(cfg_wdata), .ridx(idx_q), .rword(lut_rword),
    .look_addr(up_addr), .look_ns(look_ns)
  );

  bsf_gate i_gate (
    .up_valid(up_valid), .up_ns(up_ns), .blk_ns_bit(look_ns),
    .err_mode(err_mode), .dn_rdata(dn_rdata), .dn_valid(dn_valid),
    .up_rdata(up_rdata), .up_err(up_err), .blk_evt(blk_evt)
  );

  assign dn_write  = up_write;
  assign dn_addr   = up_addr;
  assign dn_size   = up_size;
  assign dn_wdata  = up_wdata;
  assign blk_write = blk_evt && up_write;
  assign blk_ns    = blk_evt && up_ns;
  assign blk_addr  = blk_evt ? up_addr : '0;
  assign blk_size  = blk_evt ? up_size : '0;
  assign irq       = irq_stat_q && irq_en_q;
endmodule

// File: rtl/bsf_chk.sv
module bsf_chk #(
  parameter int N_WORDS = 4,
  parameter int AW      = 12,
  parameter int IW      = 2
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          up_valid,
  input logic          up_write,
  input logic [AW-1:0] up_addr,
  input logic [31:0]   up_rdata,
  input logic          up_err,
  input logic          dn_valid,
  input logic [AW-1:0] dn_addr,
  input logic          blk_evt,
  input logic          irq_stat_q,
  input logic [IW-1:0] idx_q
);
  p_fwd_pass_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dn_valid |-> (up_valid && dn_addr == up_addr));

  p_stop_excl_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dn_valid && blk_evt));

  p_stop_zero_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_evt && !up_write) |-> (up_rdata == 32'd0));

  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    32'(idx_q) < N_WORDS);

  p_stat_set_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk_evt |=> irq_stat_q);

  p_stat_cause_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_stat_q) |-> $past(blk_evt));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    up_err |-> blk_evt);
endmodule

bind blk_sec_filter bsf_chk #(.N_WORDS(N_WORDS), .AW(AW), .IW(IW)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .up_valid(up_valid),
  .up_write(up_write), .up_addr(up_addr), .up_rdata(up_rdata),
  .up_err(up_err), .dn_valid(dn_valid), .dn_addr(dn_addr),
  .blk_evt(blk_evt), .irq_stat_q(irq_stat_q), .idx_q(idx_q)
);

// File: tb/test_blk_sec_filter.sv
module test_blk_sec_filter;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_sel, cfg_wr;
  logic [2:0]    cfg_addr;
  logic [1:0]    cfg_size;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic          up_valid, up_write, up_ns;
  logic [AW-1:0] up_addr;
  logic [1:0]    up_size;
  logic [31:0]   up_wdata, up_rdata;
  logic          up_err, dn_valid, dn_write;
  logic [AW-1:0] dn_addr;
  logic [1:0]    dn_size;
  logic [31:0]   dn_wdata, dn_rdata;
  logic          blk_evt, blk_write, blk_ns;
  logic [AW-1:0] blk_addr;
  logic [1:0]    blk_size;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  blk_sec_filter i_blk_sec_filter (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    cfg_sel = 1; cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_size = sz;
    @(posedge clk); @(negedge clk);
    cfg_sel = 0; cfg_wr = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    cfg_sel = 1; cfg_wr = 0; cfg_addr = a; cfg_size = sz;
    #1 d = cfg_rdata;
    @(posedge clk); @(negedge clk);
    cfg_sel = 0;
  endtask

  task automatic reg_chk(string tag, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    chk(tag, d, exp);
  endtask

  // one access; checks pass/stop behaviour in the cycle it is presented
  task automatic xact(string tag, logic w, logic ns, logic [AW-1:0] a,
                      logic exp_pass, logic exp_err = 1'b0);
    up_valid = 1; up_write = w; up_ns = ns; up_addr = a; up_size = 2'd2;
    up_wdata = 32'hA5A5_0000 | 32'(a); dn_rdata = 32'h1234_0000 | 32'(a);
    #1;
    chk({tag, " dn_valid"}, 32'(dn_valid), 32'(exp_pass));
    chk({tag, " blk_evt"}, 32'(blk_evt), 32'(!exp_pass));
    chk({tag, " up_err"}, 32'(up_err), 32'(exp_err));
    if (!w) chk({tag, " rdata"}, up_rdata, exp_pass ? dn_rdata : 32'd0);
    if (exp_pass) begin
      chk({tag, " dn_addr"}, 32'(dn_addr), 32'(a));
      if (w) chk({tag, " dn_wdata"}, dn_wdata, up_wdata);
    end else begin
      chk({tag, " blk_addr"}, 32'(blk_addr), 32'(a));
      chk({tag, " blk_attr"}, {30'd0, blk_write, blk_ns}, {30'd0, w, ns});
      chk({tag, " blk_size"}, 32'(blk_size), 32'd2);
    end
    @(posedge clk); @(negedge clk);
    up_valid = 0;
  endtask

  task automatic t_reset();
    chk("R10 irq", 32'(irq), 0);
    reg_chk("R10 ctrl", 3'd0, 0);
    reg_chk("R10 index", 3'd1, 0);
    reg_chk("R10 table", 3'd2, 0);
    reg_chk("R10 status", 3'd3, 0);
    reg_chk("R10 enable", 3'd4, 0);
    reg_chk("R10 unmapped", 3'd7, 0);
  endtask

  task automatic t_default_secure();
    xact("R2 sec read blk0", 0, 0, 12'h000, 1);
    xact("R2 sec write blk127", 1, 0, 12'hFE4, 1);
    xact("R3 ns read blk0", 0, 1, 12'h010, 0);
    xact("R3 ns write blk5", 1, 1, 12'h0A0, 0);
  endtask

  task automatic t_index_and_table();
    reg_wr(3'd1, 32'd6);
    reg_chk("R4 index mod", 3'd1, 2);
    reg_wr(3'd1, 32'd11);
    reg_chk("R4 index mod 11", 3'd1, 3);
    reg_wr(3'd1, 32'd2);
    reg_wr(3'd2, 32'h8000_0001);
    reg_chk("R5 table readback", 3'd2, 32'h8000_0001);
    reg_chk("R6 no step when off", 3'd1, 2);
    // block 64 = word 2 bit 0, block 95 = word 2 bit 31
    xact("R1 R5 ns blk64", 0, 1, 12'h800, 1);
    xact("R2 sec blk64", 0, 0, 12'h804, 0);
    xact("R1 sec blk65", 0, 0, 12'h820, 1);
    xact("R1 ns blk65", 1, 1, 12'h820, 0);
    xact("R1 ns blk95", 1, 1, 12'hBE4, 1);
    xact("R1 sec blk96", 0, 0, 12'hC00, 1);
  endtask

  task automatic t_autoinc();
    reg_wr(3'd0, 32'd1);
    reg_wr(3'd1, 32'd3);
    reg_wr(3'd2, 32'h0000_0004);
    reg_chk("R6 wrap after last", 3'd1, 0);
    reg_wr(3'd2, 32'd0, 2'd0);
    reg_chk("R6 byte no step", 3'd1, 0);
    reg_chk("R6 word read value", 3'd2, 0);
    reg_chk("R6 word read step", 3'd1, 1);
    reg_wr(3'd0, 32'd0);
    reg_chk("R6 off read", 3'd2, 0);
    reg_chk("R6 off no step", 3'd1, 1);
    xact("R1 ns blk98", 0, 1, 12'hC40, 1);
    xact("R2 sec blk98", 0, 0, 12'hC40, 0);
  endtask

  task automatic t_irq();
    reg_wr(3'd5, 32'd1);
    reg_chk("R7 cleared", 3'd3, 0);
    xact("R3 stop", 0, 1, 12'h100, 0);
    reg_chk("R7 sticky set", 3'd3, 1);
    chk("R8 irq masked", 32'(irq), 0);
    reg_wr(3'd4, 32'd1);
    chk("R8 irq high", 32'(irq), 1);
    reg_wr(3'd5, 32'd0);
    reg_chk("R7 clear 0 ignored", 3'd3, 1);
    reg_wr(3'd5, 32'd1);
    chk("R8 irq low after clear", 32'(irq), 0);
    // clear and stopped access in the same cycle: set wins
    cfg_sel = 1; cfg_wr = 1; cfg_addr = 3'd5; cfg_wdata = 1; cfg_size = 2'd2;
    up_valid = 1; up_write = 0; up_ns = 1; up_addr = 12'h100; up_size = 2'd2;
    @(posedge clk); @(negedge clk);
    cfg_sel = 0; cfg_wr = 0; up_valid = 0;
    reg_chk("R7 set beats clear", 3'd3, 1);
    chk("R8 irq after race", 32'(irq), 1);
    reg_wr(3'd4, 32'd0);
    chk("R8 irq disabled", 32'(irq), 0);
  endtask

  task automatic t_err();
    reg_wr(3'd0, 32'd2);
    xact("R9 err stop", 0, 0, 12'h800, 0, 1);
    xact("R9 no err pass", 0, 1, 12'h800, 1, 0);
    reg_wr(3'd0, 32'd0);
    xact("R9 ok stop", 1, 0, 12'h800, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_sel = 0; cfg_wr = 0; cfg_addr = 0; cfg_size = 0; cfg_wdata = 0;
    up_valid = 0; up_write = 0; up_ns = 0; up_addr = 0; up_size = 0;
    up_wdata = 0; dn_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_secure();
    t_index_and_table();
    t_autoinc();
    t_irq();
    t_err();
    finish_run();
  end
endmodule